// File: doc/BRIEF.md
# Timebase Counter with Input Capture

This block is a free-running 8-bit timebase. An internal prescaler divides the system clock by 32, and optionally by a further 2. The counter runs from 0 up to 249 and then returns to 0, so every full period produces an overflow event. The overflow sets a status flag and can raise an interrupt request. Software can use it as a fixed 250-count tick, which gives 1 ms at an 8 MHz clock, or 2 ms when the period-double mode is on.

A capture channel sits beside the counter. It watches an external pin through a two-flop synchronizer. On any change of the pin, in either direction, it stores the counter value in a capture register, sets a capture flag and can request an interrupt.

Software reaches the block through a small register bus with two addresses: a control/status register and the capture data register. Both flags are cleared as a side effect of reading the register that holds them, so no write is needed to acknowledge an event.

Top module: `tbc_top`

## Requirements
- R1: After synchronous reset the counter is 0, the control/status register and capture register read 0x00, and both interrupt outputs are low.
- R2: With period-double off, the counter advances once every 32 clock edges. It goes from 249 back to 0, and that wrap is an overflow. The first overflow flag becomes visible after the 8000th rising edge following reset release.
- R3: With period-double (control/status bit 2) set before the 32nd edge after reset, the counter advances once every 64 edges. The first overflow becomes visible after edge 16000.
- R4: An overflow sets control/status bit 0. `irq_ovf` is high while bit 0 and the overflow enable (bit 1) are both 1.
- R5: A read of the control/status register (`bus_rd` high, `bus_sel`=0) clears bit 0 at that clock edge. If an overflow occurs at the same edge, the flag stays 1.
- R6: Every change of `cap_pin` (rising or falling) passes through two synchronizing flops. The capture happens at the third rising edge after the change and stores the counter value held just before that edge. The capture register is read at `bus_sel`=1.
- R7: A capture sets control/status bit 3. `irq_cap` is high while bit 3 and the capture enable (bit 4) are both 1. A read of the capture register clears bit 3, but a capture at the same edge wins.
- R8: The control/status register reads {3'b000, capture enable, capture flag, period-double, overflow enable, overflow flag} from bit 7 down to bit 0. `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R9: Only bits 4, 2 and 1 are writable (`bus_wr` high, `bus_sel`=0). Writes to bits 3 and 0, and any write at `bus_sel`=1, leave the flags and the capture register unchanged. The counter has no bus access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture input |
| bus_sel | input | 1 | Register select: 0 control/status, 1 capture data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; the read clears the selected flag at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally while bus_rd is high |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
A prescaler or counter that is off by a single count moves every later overflow. The error therefore shows on `irq_ovf` within one 8000- or 16000-cycle period, and it also shows as a wrong captured value at the next capture read. A wrong synchronizer depth or a broken edge detector shows up as a capture flag that is missing, duplicated or one cycle late, and this is visible on `irq_cap` within three cycles of the pin change. Errors in set/clear priority appear only when a flag-clearing read lands on the same edge as an event, so those edges are driven deliberately as well as by chance.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

    localparam int DATA_W      = 8;
    localparam int DEF_CNT_W   = 8;
    localparam int DEF_WRAP    = 249;
    localparam int DEF_PRE_DIV = 32;
    localparam int DEF_SYNC    = 2;

    typedef enum logic {
        SEL_CSR = 1'b0,
        SEL_CAP = 1'b1
    } sel_e;

    typedef struct packed {
        logic cap_ie;
        logic dbl;
        logic ovf_ie;
    } ctrl_t;

    typedef struct packed {
        logic cap_flag;
        logic ovf_flag;
    } flags_t;

    // Status word layout; bit positions are software-visible.
    function automatic logic [DATA_W-1:0] pack_csr(ctrl_t c, flags_t f);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[4] = c.cap_ie;
        w[3] = f.cap_flag;
        w[2] = c.dbl;
        w[1] = c.ovf_ie;
        w[0] = f.ovf_flag;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.cap_ie = w[4];
        c.dbl    = w[2];
        c.ovf_ie = w[1];
        return c;
    endfunction

    // Flag next state: a hardware event takes priority over a clearing read.
    function automatic logic flag_next(logic cur, logic set_ev, logic clr_rd);
        if (set_ev)      return 1'b1;
        else if (clr_rd) return 1'b0;
        else             return cur;
    endfunction

endpackage

// File: rtl/tbc_prescaler.sv
module tbc_prescaler #(
    parameter int PRE_DIV = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic dbl,
    output logic tick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             half_q;
    logic             pre_last;

    assign pre_last = (pre_q == PRE_LAST);
    assign tick     = pre_last && (!dbl || half_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            half_q <= 1'b0;
        end else begin
            pre_q <= pre_last ? '0 : pre_q + 1'b1;
            if (pre_last) begin
                half_q <= ~half_q;
            end
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2

endmodule

// File: rtl/tbc_counter.sv
module tbc_counter #(
    parameter int CNT_W = 8,
    parameter int WRAP  = 249
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_ev
);
    localparam logic [CNT_W-1:0] WRAP_V = CNT_W'(WRAP);

    assign wrap_ev = tick && (cnt == WRAP_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == WRAP_V) ? '0 : cnt + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= WRAP_V); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap_ev |=> (cnt == '0)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R2

endmodule

// File: rtl/tbc_capture.sv
module tbc_capture #(
    parameter int CNT_W = 8,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin,
    input  logic [CNT_W-1:0] cnt,
    output logic             cap_ev,
    output logic [CNT_W-1:0] cap_val
);
    // chain[SYNC-1] is the synchronized pin, chain[SYNC] its previous value.
    logic [SYNC:0] chain;

    assign cap_ev = chain[SYNC] ^ chain[SYNC-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain   <= '0;
            cap_val <= '0;
        end else begin
            chain <= {chain[SYNC-1:0], pin};
            if (cap_ev) begin
                cap_val <= cnt;
            end
        end
    end

    AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
        cap_ev |=> (cap_val == $past(cnt))); // R6
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_ev |=> $stable(cap_val)); // R9

endmodule

// File: rtl/tbc_regs.sv
module tbc_regs
    import tbc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf_ev,
    input  logic              cap_ev,
    input  logic [CNT_W-1:0]  cap_val,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_ovf,
    output logic              irq_cap
);
    sel_e   sel_v;
    flags_t flags;
    logic   rd_csr, rd_cap, wr_csr;
    logic   unused_wbits;

    assign sel_v        = sel_e'(sel);
    assign rd_csr       = rd && (sel_v == SEL_CSR);
    assign rd_cap       = rd && (sel_v == SEL_CAP);
    assign wr_csr       = wr && (sel_v == SEL_CSR);
    assign unused_wbits = ^{wdata[7:5], wdata[3], wdata[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            flags <= '0;
        end else begin
            if (wr_csr) begin
                ctrl <= unpack_ctrl(wdata);
            end
            flags.ovf_flag <= flag_next(flags.ovf_flag, ovf_ev, rd_csr);
            flags.cap_flag <= flag_next(flags.cap_flag, cap_ev, rd_cap);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (sel_v)
                SEL_CSR: rdata = pack_csr(ctrl, flags);
                SEL_CAP: rdata = DATA_W'(cap_val);
                default: rdata = '0;
            endcase
        end
    end

    assign irq_ovf = flags.ovf_flag && ctrl.ovf_ie;
    assign irq_cap = flags.cap_flag && ctrl.cap_ie;

    AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ovf_ev |=> flags.ovf_flag); // R5
    AST_OVF_RDCLR: assert property (@(posedge clk) disable iff (rst)
        (rd_csr && !ovf_ev) |=> !flags.ovf_flag); // R5
    AST_CAP_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        cap_ev |=> flags.cap_flag); // R7
    AST_CAP_RDCLR: assert property (@(posedge clk) disable iff (rst)
        (rd_cap && !cap_ev) |=> !flags.cap_flag); // R7
    AST_RD_UPPER: assert property (@(posedge clk) disable iff (rst)
        rd_csr |-> (rdata[7:5] == 3'b000)); // R8
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (rdata == '0)); // R8
    AST_FLAG_WR_IGN: assert property (@(posedge clk) disable iff (rst)
        (wr && !rd && !ovf_ev && !cap_ev) |=> $stable(flags)); // R9

endmodule

// File: rtl/tbc_top.sv
module tbc_top
    import tbc_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int WRAP    = DEF_WRAP,
    parameter int PRE_DIV = DEF_PRE_DIV,
    parameter int SYNC    = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_pin,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_ovf,
    output logic              irq_cap
);
    ctrl_t            ctrl;
    logic             tick;
    logic             wrap_ev;
    logic             cap_ev;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap_val;

    tbc_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .dbl  (ctrl.dbl),
        .tick (tick)
    );

    tbc_counter #(.CNT_W(CNT_W), .WRAP(WRAP)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cnt     (cnt),
        .wrap_ev (wrap_ev)
    );

    tbc_capture #(.CNT_W(CNT_W), .SYNC(SYNC)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .pin     (cap_pin),
        .cnt     (cnt),
        .cap_ev  (cap_ev),
        .cap_val (cap_val)
    );

    tbc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .ovf_ev  (wrap_ev),
        .cap_ev  (cap_ev),
        .cap_val (cap_val),
        .ctrl    (ctrl),
        .rdata   (bus_rdata),
        .irq_ovf (irq_ovf),
        .irq_cap (irq_cap)
    );

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_ovf) |-> ($past(wrap_ev) || $past(bus_wr))); // R4

endmodule

// File: tb/tbc_top_tb.sv
module tbc_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cap_pin = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_ovf, irq_cap;

    int nvec = 0;
    int nerr = 0;
    int ecount = 0;

    always #5ns clk = ~clk;

    tbc_top u_dut (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_ovf(irq_ovf), .irq_cap(irq_cap)
    );

    // Behavioural expectation built from the requirements.
    logic [4:0] m_pre;
    logic       m_half, m_s1, m_s2, m_s3;
    logic [7:0] m_cnt, m_cap;
    logic       m_ovf, m_icf, m_ie_cap, m_dbl, m_ie_ovf;

    always @(posedge clk) begin
        logic tk;
        tk = (m_pre == 5'd31) && (!m_dbl || m_half);
        if (rst) begin
            ecount <= 0;
            m_pre <= '0; m_half <= 1'b0; m_cnt <= '0; m_cap <= '0;
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0;
            m_ovf <= 1'b0; m_icf <= 1'b0;
            m_ie_cap <= 1'b0; m_dbl <= 1'b0; m_ie_ovf <= 1'b0;
        end else begin
            ecount <= ecount + 1;
            m_pre <= m_pre + 5'd1;
            if (m_pre == 5'd31) m_half <= ~m_half;
            if (tk) m_cnt <= (m_cnt == 8'd249) ? 8'd0 : m_cnt + 8'd1;
            m_s1 <= cap_pin; m_s2 <= m_s1; m_s3 <= m_s2;
            if (m_s2 != m_s3) m_cap <= m_cnt;
            if (tk && m_cnt == 8'd249) m_ovf <= 1'b1;
            else if (bus_rd && !bus_sel) m_ovf <= 1'b0;
            if (m_s2 != m_s3) m_icf <= 1'b1;
            else if (bus_rd && bus_sel) m_icf <= 1'b0;
            if (bus_wr && !bus_sel) begin
                m_ie_cap <= bus_wdata[4];
                m_dbl    <= bus_wdata[2];
                m_ie_ovf <= bus_wdata[1];
            end
        end
    end

    function automatic logic [7:0] exp_rdata();
        if (!bus_rd) return 8'h00;
        if (bus_sel) return m_cap;
        return {3'b000, m_ie_cap, m_icf, m_dbl, m_ie_ovf, m_ovf};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s at edge %0d: actual=%02h expected=%02h", req, ecount, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, then compare against the model.
    task automatic cyc(input logic wr, input logic rd, input logic sel, input logic [7:0] wd);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_sel = sel; bus_wdata = wd;
        #1ns;
        chk("R4 irq_ovf", {7'b0, irq_ovf}, {7'b0, m_ovf && m_ie_ovf});
        chk("R7 irq_cap", {7'b0, irq_cap}, {7'b0, m_icf && m_ie_cap});
        chk(sel ? "R6 capture read" : "R8 status read", bus_rdata, exp_rdata());
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cap_pin = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_sel = 1'b0; bus_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        #1_900_000ns;
        nerr++;
        $display("FAIL watchdog expired at edge %0d", ecount);
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1357);

        // Phase A: reset values, write masking, first overflow, capture.
        do_reset();
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        chk("R1 status after reset", bus_rdata, 8'h00);
        chk("R1 irqs after reset", {6'b0, irq_ovf, irq_cap}, 8'h00);
        cyc(1'b0, 1'b1, 1'b1, 8'h00);
        chk("R1 capture after reset", bus_rdata, 8'h00);
        cyc(1'b1, 1'b0, 1'b0, 8'hFB);
        idle();
        chk("R8 rdata idle", bus_rdata, 8'h00);
        cyc(1'b1, 1'b0, 1'b1, 8'h5A);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        chk("R9 only enables written", bus_rdata, 8'h12);
        cyc(1'b0, 1'b1, 1'b1, 8'h00);
        chk("R9 capture write ignored", bus_rdata, 8'h00);

        while (ecount < 7998) idle();
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        chk("R2 no overflow before edge 8000", {7'b0, irq_ovf}, 8'h00);
        idle();
        chk("R5 set wins over same-edge read", {7'b0, irq_ovf}, 8'h01);
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        chk("R4 overflow flag bit0", bus_rdata, 8'h13);
        idle();
        chk("R5 read cleared flag", {7'b0, irq_ovf}, 8'h00);

        while (ecount < 8099) idle();
        @(negedge clk);
        cap_pin = 1'b1;
        #1ns;
        idle();                          // edge count 8101
        cyc(1'b0, 1'b1, 1'b1, 8'h00);    // read at edge 8102, capture at 8103
        chk("R7 no capture before third edge", {7'b0, irq_cap}, 8'h00);
        cyc(1'b0, 1'b1, 1'b1, 8'h00);
        chk("R7 set wins over same-edge read", {7'b0, irq_cap}, 8'h01);
        chk("R6 captured value", bus_rdata, 8'd3);
        idle();
        chk("R7 read cleared flag", {7'b0, irq_cap}, 8'h00);
        @(negedge clk);
        cap_pin = 1'b0;                  // falling edge, captured at edge +3
        #1ns;
        repeat (3) idle();
        chk("R6 falling edge captured", {7'b0, irq_cap}, 8'h01);

        // Phase B: doubled period.
        do_reset();
        cyc(1'b1, 1'b0, 1'b0, 8'h06);
        while (ecount < 15998) idle();
        idle();
        chk("R3 no overflow before edge 16000", {7'b0, irq_ovf}, 8'h00);
        idle();
        chk("R3 overflow at edge 16000", {7'b0, irq_ovf}, 8'h01);

        // Phase C: random traffic checked against the model.
        for (int i = 0; i < 40000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 3) begin
                @(negedge clk);
                cap_pin = ~cap_pin;
                #1ns;
            end
            r = int'($urandom % 100);
            if (r < 2)      cyc(1'b1, 1'b0, 1'($urandom % 2), 8'($urandom));
            else if (r < 6) cyc(1'b0, 1'b1, 1'($urandom % 2), 8'h00);
            else            idle();
        end

        summary();
        $finish;
    end
endmodule